// File: doc/BRIEF.md
# Multi-unicast destination expander

The expander takes one fetched message descriptor and turns it into a series of unicast send requests. A descriptor has three parts: a distribution vector (256 bits by default), a 128-bit header and a 128-bit payload. Every set bit in the vector names one destination node. The node ID for bit `i` is a 15-bit base field from the header plus `i`, and the sum wraps modulo 2^15. Each request carries that node ID, the bit index, the whole header and payload as a template, and a flag that asks for delivery to both sockets. Requests leave over a valid/ready interface, lowest bit index first.

The header is checked when the descriptor is accepted. Only endpoint multi-unicast descriptors are served. These have the multi-level format bit clear, a zero sub-node field and the endpoint message command code. Any other descriptor is refused with a one-cycle error pulse and produces no requests. Descriptors can be linked through a chaining bit in the header. A descriptor with that bit set ends quietly and the block returns to accepting input. The completion pulse comes only after the last descriptor of the activation, the one with the chaining bit clear.

The control is a five-state machine:
- **IDLE** accepts a descriptor. It moves to SCAN on a good header and to FAULT on a bad one.
- **SCAN** picks the first set bit. It moves to SEND if a bit is found, otherwise to DONE, or back to IDLE when the descriptor is chained.
- **SEND** presents a request. On each handshake it loads the next bit and stays, or leaves as SCAN does once no bits remain.
- **DONE** pulses completion for one cycle and returns to IDLE.
- **FAULT** pulses the error for one cycle and returns to IDLE.

Top module: `ucast_expander`

## Requirements
- R1: A descriptor is refused when header bit 105 (multi-level) is 1, when header bits 5:0 (sub-node) are nonzero, or when header bits 28:21 (command) differ from 8'h38. A refused descriptor raises `desc_err` for exactly the one cycle after acceptance and never raises `req_valid`.
- R2: The request for vector bit `i` carries `req_dest` = (header bits 20:6 + `i`) modulo 2^15.
- R3: Requests appear in strictly ascending bit order, one for each set bit and one for each accepted handshake. While `req_valid` is high and `req_ready` is low, the request does not change.
- R4: For a descriptor with header bit 106 clear, `act_done` is high for exactly one cycle. That cycle is the one after the last request handshake. For an all-zero vector it is the second cycle after acceptance.
- R5: A descriptor with header bit 106 (chaining) set never raises `act_done`. After its last handshake, or in the second cycle after acceptance if its vector is empty, the block is idle again with `desc_ready` high.
- R6: Every request forwards the accepted header and payload unchanged. `req_both` equals header bit 101.
- R7: After reset, `desc_ready` is 1 and `req_valid`, `act_done` and `desc_err` are 0. `desc_ready` is high only while the block is idle.
- R8: The first request of a nonempty descriptor is valid in the second cycle after acceptance and not in the first. With `req_ready` held high, each later request follows one cycle after the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle; the descriptor is taken on this edge |
| desc_dist | input | VEC_W | Distribution vector, bit `i` names node base+`i` |
| desc_hdr | input | 128 | Message header |
| desc_payload | input | 128 | Message payload |
| req_valid | output | 1 | Unicast request present |
| req_ready | input | 1 | Request taken |
| req_dest | output | NODE_W | Destination node ID |
| req_bit | output | IDX_W | Vector bit that produced this request |
| req_both | output | 1 | Deliver to both sockets |
| req_hdr | output | 128 | Header template |
| req_payload | output | 128 | Payload template |
| act_done | output | 1 | One-cycle pulse when an activation completes |
| desc_err | output | 1 | One-cycle pulse when a descriptor is refused |

## Verification
Each descriptor is accepted on the edge where `desc_valid` and `desc_ready` are both high. The error pulse is due one cycle after that edge. The first request, or the completion of an empty vector, is due two cycles after it. Each later request is due one cycle after the previous handshake, and completion is due one cycle after the last handshake. The bench drives all inputs and samples all outputs on the falling edge. It counts those falling edges from the acceptance edge and compares each output only in the cycle where that output is due. Stall cycles are inserted on odd bit indices to show that a request holds still and that no request is skipped.

// File: rtl/ucast_expander_pkg.sv
package ucast_expander_pkg;

    localparam int HDR_W  = 128;
    localparam int PAY_W  = 128;
    localparam int NODE_W = 15;

    // header field positions that the decoder depends on
    localparam int SUBN_LO   = 0;
    localparam int SUBN_HI   = 5;
    localparam int BASE_LO   = 6;
    localparam int BASE_HI   = 20;
    localparam int CMD_LO    = 21;
    localparam int CMD_HI    = 28;
    localparam int BOTH_BIT  = 101;
    localparam int MULTI_BIT = 105;
    localparam int CHAIN_BIT = 106;

    localparam logic [7:0] ENDPOINT_CMD = 8'h38;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SEND,
        ST_DONE,
        ST_FAULT
    } xp_state_e;

    typedef struct packed {
        logic              ok;
        logic              chain;
        logic              both;
        logic [NODE_W-1:0] base;
    } hdr_info_t;

endpackage

// File: rtl/ucast_hdr_decode.sv
module ucast_hdr_decode
    import ucast_expander_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output hdr_info_t        info
);

    logic       subnode_zero;
    logic       cmd_match;
    logic       unicast_mode;

    always_comb begin
        subnode_zero = (hdr[SUBN_HI:SUBN_LO] == '0);
        cmd_match    = (hdr[CMD_HI:CMD_LO] == ENDPOINT_CMD);
        unicast_mode = ~hdr[MULTI_BIT];
        info.ok      = subnode_zero & cmd_match & unicast_mode;
        info.chain   = hdr[CHAIN_BIT];
        info.both    = hdr[BOTH_BIT];
        info.base    = hdr[BASE_HI:BASE_LO];
    end

endmodule

// File: rtl/ucast_low_scan.sv
module ucast_low_scan #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    logic [W:0]   below;
    logic [W-1:0] pick;

    assign below[0] = 1'b0;

    // prefix OR chain: pick marks the lowest set bit only
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign pick[g]      = vec[g] & ~below[g];
        assign below[g + 1] = below[g] | vec[g];
    end

    assign any  = below[W];
    assign rest = vec & ~pick;

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (pick[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/ucast_dest_add.sv
module ucast_dest_add #(
    parameter int NW = 15,
    parameter int IW = 8
) (
    input  logic [NW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [NW-1:0] dest
);

    // sum truncated to NW bits: wraps modulo 2^NW
    assign dest = base + NW'(idx);

endmodule

// File: rtl/ucast_expander.sv
module ucast_expander
    import ucast_expander_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [VEC_W-1:0]  desc_dist,
    input  logic [HDR_W-1:0]  desc_hdr,
    input  logic [PAY_W-1:0]  desc_payload,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [NODE_W-1:0] req_dest,
    output logic [IDX_W-1:0]  req_bit,
    output logic              req_both,
    output logic [HDR_W-1:0]  req_hdr,
    output logic [PAY_W-1:0]  req_payload,
    output logic              act_done,
    output logic              desc_err
);

    xp_state_e state_q, state_d;

    hdr_info_t          in_info;
    logic [VEC_W-1:0]   rem_q;
    logic [IDX_W-1:0]   idx_q;
    logic [HDR_W-1:0]   hdr_q;
    logic [PAY_W-1:0]   pay_q;
    logic [NODE_W-1:0]  base_q;
    logic               both_q;
    logic               chain_q;

    logic               scan_any;
    logic [IDX_W-1:0]   scan_idx;
    logic [VEC_W-1:0]   scan_rest;
    logic [NODE_W-1:0]  dest_w;

    logic               accept;
    logic               advance;

    ucast_hdr_decode u_dec (
        .hdr  (desc_hdr),
        .info (in_info)
    );

    ucast_low_scan #(.W(VEC_W), .IW(IDX_W)) u_scan (
        .vec  (rem_q),
        .any  (scan_any),
        .idx  (scan_idx),
        .rest (scan_rest)
    );

    ucast_dest_add #(.NW(NODE_W), .IW(IDX_W)) u_add (
        .base (base_q),
        .idx  (idx_q),
        .dest (dest_w)
    );

    assign accept  = (state_q == ST_IDLE) && desc_valid;
    assign advance = (state_q == ST_SCAN) ||
                     ((state_q == ST_SEND) && req_ready);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (desc_valid) state_d = in_info.ok ? ST_SCAN : ST_FAULT;
            end
            ST_SCAN: begin
                if (scan_any)     state_d = ST_SEND;
                else if (chain_q) state_d = ST_IDLE;
                else              state_d = ST_DONE;
            end
            ST_SEND: begin
                if (req_ready) begin
                    if (scan_any)     state_d = ST_SEND;
                    else if (chain_q) state_d = ST_IDLE;
                    else              state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // descriptor and bit-pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            idx_q   <= '0;
            hdr_q   <= '0;
            pay_q   <= '0;
            base_q  <= '0;
            both_q  <= 1'b0;
            chain_q <= 1'b0;
        end else begin
            if (accept) begin
                rem_q   <= desc_dist;
                hdr_q   <= desc_hdr;
                pay_q   <= desc_payload;
                base_q  <= in_info.base;
                both_q  <= in_info.both;
                chain_q <= in_info.chain;
            end else if (advance && scan_any) begin
                idx_q <= scan_idx;
                rem_q <= scan_rest;
            end
        end
    end

    // outputs
    always_comb begin
        desc_ready = 1'b0;
        req_valid  = 1'b0;
        act_done   = 1'b0;
        desc_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:  desc_ready = 1'b1;
            ST_SCAN:  ;
            ST_SEND:  req_valid  = 1'b1;
            ST_DONE:  act_done   = 1'b1;
            ST_FAULT: desc_err   = 1'b1;
            default:  ;
        endcase
    end

    assign req_dest    = dest_w;
    assign req_bit     = idx_q;
    assign req_both    = both_q;
    assign req_hdr     = hdr_q;
    assign req_payload = pay_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_dest) && $stable(req_bit)); // R3

    AST_ORDER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || (req_bit > $past(req_bit))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        act_done |=> !act_done && desc_ready); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |=> !desc_err && !req_valid && desc_ready); // R1

    AST_FIRST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |=> !req_valid && !act_done); // R8

endmodule

// File: tb/ucast_expander_test.sv
module ucast_expander_test;

    localparam int VW = 8;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [VW-1:0]     desc_dist = '0;
    logic [127:0]      desc_hdr = '0;
    logic [127:0]      desc_payload = '0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [14:0]       req_dest;
    logic [IW-1:0]     req_bit;
    logic              req_both;
    logic [127:0]      req_hdr;
    logic [127:0]      req_payload;
    logic              act_done;
    logic              desc_err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ucast_expander #(.VEC_W(VW), .IDX_W(IW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .desc_dist    (desc_dist),
        .desc_hdr     (desc_hdr),
        .desc_payload (desc_payload),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_dest     (req_dest),
        .req_bit      (req_bit),
        .req_both     (req_both),
        .req_hdr      (req_hdr),
        .req_payload  (req_payload),
        .act_done     (act_done),
        .desc_err     (desc_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_desc(input logic [VW-1:0] vec, input logic [14:0] base,
                            input logic chain, input logic [5:0] sub,
                            input logic [7:0] cmd, input logic ml,
                            input logic both, input logic stall);
        logic [127:0] hdr;
        logic [127:0] pay;
        logic         refused;
        logic [14:0]  expd;
        hdr = '0;
        hdr[5:0]   = sub;
        hdr[20:6]  = base;
        hdr[28:21] = cmd;
        hdr[77]    = vec[0];
        hdr[101]   = both;
        hdr[105]   = ml;
        hdr[106]   = chain;
        pay = 128'({base, vec}) ^ {4{32'hA5C3_0F1E}};
        refused = ml || (sub != 6'd0) || (cmd != 8'h38);

        @(negedge clk);
        desc_dist    = vec;
        desc_hdr     = hdr;
        desc_payload = pay;
        desc_valid   = 1'b1;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;

        if (refused) begin
            chk(desc_err == 1'b1, "R1 err pulse", desc_err, 1);
            chk(req_valid == 1'b0, "R1 no request", req_valid, 0);
            @(negedge clk);
            chk(desc_err == 1'b0 && req_valid == 1'b0, "R1 err single", desc_err, 0);
            chk(desc_ready == 1'b1, "R7 idle after err", desc_ready, 1);
            return;
        end

        chk(req_valid == 1'b0 && act_done == 1'b0, "R8 first cycle quiet", req_valid, 0);
        @(negedge clk);

        for (int i = 0; i < VW; i++) begin
            if (vec[i]) begin
                expd = base + 15'(i);
                chk(req_valid == 1'b1, "R8 request due", req_valid, 1);
                chk(req_dest == expd, "R2 dest", req_dest, expd);
                chk(req_bit == IW'(i), "R3 order", req_bit, i);
                chk(req_both == both, "R6 both", req_both, both);
                chk(req_hdr == hdr && req_payload == pay, "R6 template",
                    req_payload[31:0], pay[31:0]);
                if (stall && i[0]) begin
                    req_ready = 1'b0;
                    @(negedge clk);
                    chk(req_valid == 1'b1 && req_dest == expd, "R3 hold", req_dest, expd);
                    req_ready = 1'b1;
                end
                @(negedge clk);
            end
        end

        chk(req_valid == 1'b0, "R3 no extra request", req_valid, 0);
        if (chain) begin
            chk(act_done == 1'b0, "R5 no done in chain", act_done, 0);
            chk(desc_ready == 1'b1, "R5 ready after chained", desc_ready, 1);
        end else begin
            chk(act_done == 1'b1, "R4 done due", act_done, 1);
            @(negedge clk);
            chk(act_done == 1'b0 && desc_ready == 1'b1, "R4 done single", act_done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(desc_ready == 1'b1 && req_valid == 1'b0, "R7 in reset", desc_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1'b1, "R7 ready", desc_ready, 1);
        chk(req_valid == 1'b0 && act_done == 1'b0 && desc_err == 1'b0,
            "R7 outputs low", {req_valid, act_done, desc_err}, 0);

        // full sweep of all vectors, bases near and far from wrap
        for (int v = 0; v < 256; v++) begin
            logic [14:0] b;
            b = (v % 4 == 0) ? 15'h7FFC : 15'((v * 1237) % 32768);
            run_desc(VW'(v), b, 1'b0, 6'd0, 8'h38, 1'b0, v[1], (v % 3 == 1));
        end

        // chained activation: done only after the last descriptor (R5)
        run_desc(8'h05, 15'h0100, 1'b1, 6'd0, 8'h38, 1'b0, 1'b0, 1'b0);
        run_desc(8'h00, 15'h0200, 1'b1, 6'd0, 8'h38, 1'b0, 1'b1, 1'b0);
        run_desc(8'h80, 15'h7FFF, 1'b0, 6'd0, 8'h38, 1'b0, 1'b1, 1'b1);

        // refused headers (R1)
        run_desc(8'hFF, 15'h0010, 1'b0, 6'd0, 8'h38, 1'b1, 1'b0, 1'b0);
        run_desc(8'hFF, 15'h0010, 1'b0, 6'd1, 8'h38, 1'b0, 1'b0, 1'b0);
        run_desc(8'hFF, 15'h0010, 1'b0, 6'd0, 8'h37, 1'b0, 1'b0, 1'b0);
        run_desc(8'h0F, 15'h0010, 1'b1, 6'd32, 8'h38, 1'b0, 1'b0, 1'b0);
        run_desc(8'h11, 15'h7FF0, 1'b0, 6'd0, 8'h38, 1'b0, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule